// File: doc/BRIEF.md
# Token-Bus Event Readout Collector

The collector gathers one event's worth of data from a shared 36-bit backplane bus whenever a trigger-accept pulse arrives. Bus ownership moves by a token. The token is first granted to a single multiplicity-buffer board and then to sixteen candidate-source boards, one after another. While a board holds the token, it first sends one header word that carries the bunch-crossing identifier of the event. It then sends its data words and hands the token back.

The block checks every board's header against the identifier latched when the accept arrived. It repacks each data word into a 40-bit output word that is tagged with its origin. It frames the event between a 40-bit event header and a trailer that reports per-board errors, and writes everything into a downstream FIFO.

A board that never returns the token is abandoned after a programmable number of cycles. Accepts that arrive while a readout is busy are queued and served in order. When the FIFO reports full, the block raises a stall line so that the board holding the token freezes its bus word.

Top module: `evt_collector`

## Requirements
- R1: Without an `accept_i` pulse no token is granted and `fifo_wr_o` stays low.
- R2: For each event, `tok_o` is one-hot and is granted in this order: bit 0 for the multiplicity board, then bits 1..16 for candidate sources 0..15 in ascending order. A grant moves to the next board on the cycle after `tok_ret_i` is high.
- R3: Output words, identified by bits [39:38]. The event header is 2'b11 with the bcid in [11:0] and zeros elsewhere. A multiplicity word is 2'b01 with [37:36]=0 and [35:0] equal to the bus word. A candidate word is 2'b10 with the source number (0..15) in [37:34] and [33:0] equal to bus bits [33:0]. The trailer is 2'b00.
- R4: The first bus word a board sends is its header, with [35:34]=2'b10 and the bcid in [11:0]. The header is not written to the FIFO. The board's later words are written in arrival order: first the event header, then each board's words, then the trailer.
- R5: A board whose header has the wrong tag or bcid, or which returns the token without sending a header, sets trailer bit 17+b. Here b is 0 for the multiplicity board and 1..16 for the candidate sources. Trailer bit 37 is the OR of all trailer error bits.
- R6: If a board does not return the token within `timeout_cfg_i` non-stalled cycles (values of 1 or more), the token moves on, and trailer bit b (0..16) is set for that board.
- R7: `stall_o` is high whenever an output word is waiting and `fifo_full_i` is high. While it is high, no bus word is taken and the waiting word is held. `fifo_wr_o` is never high while `fifo_full_i` is high.
- R8: Accepts that arrive during a readout are queued up to PEND_DEPTH deep with their bcid and are served in arrival order. An accept that finds the queue full is dropped.
- R9: `err_o` takes the value of trailer bit 37 when each trailer is produced and holds it until the next trailer.
- R10: After reset `tok_o`, `fifo_wr_o`, `stall_o` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| accept_i | input | 1 | Trigger-accept pulse |
| bcid_i | input | BCID_W | Bunch-crossing identifier sampled with the accept |
| timeout_cfg_i | input | TMO_W | Token hold limit in cycles |
| tok_o | output | N_SRC+1 | One-hot token grant |
| tok_ret_i | input | 1 | Token return from the current holder |
| bus_data_i | input | BUS_W | Shared readout bus word |
| bus_vld_i | input | 1 | Bus word valid |
| stall_o | output | 1 | Back-pressure toward the token holder |
| fifo_data_o | output | OUT_W | Output FIFO write data |
| fifo_wr_o | output | 1 | Output FIFO write strobe |
| fifo_full_i | input | 1 | Output FIFO full |
| err_o | output | 1 | Error summary of the last completed event |

## Verification
The bench builds the collector with its default values: sixteen candidate sources, a four-deep accept queue and 12-bit bcids. Because the timeout limit is an input, the bench drops it to eight cycles, so a board that stays silent expires quickly and its exact hold time can be counted. The four-entry queue means six back-to-back accepts are enough to fill it and drop the last one. A periodic full pattern on the FIFO side exercises the stall path while boards are in the middle of sending words.

// File: rtl/evt_pkg.sv
package evt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HEAD  = 2'd1,
        ST_SRC   = 2'd2,
        ST_TRAIL = 2'd3
    } evt_state_e;

    // Output word tags in the two top bits
    localparam logic [1:0] TAG_TRL  = 2'b00;
    localparam logic [1:0] TAG_MULT = 2'b01;
    localparam logic [1:0] TAG_CAND = 2'b10;
    localparam logic [1:0] TAG_HEAD = 2'b11;

    // Tag a board places in the top two bits of its header word
    localparam logic [1:0] BUS_HDR_TAG = 2'b10;

endpackage

// File: rtl/evt_acc_queue.sv
module evt_acc_queue #(
    parameter int W     = 12,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           rd;
        logic [AW-1:0]           wr;
        logic [CW-1:0]           cnt;
    } q_t;

    q_t q_d, q_q;
    logic full, do_push, do_pop;

    assign full    = (q_q.cnt == CW'(DEPTH));
    assign empty   = (q_q.cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = q_q.mem[q_q.rd];

    always_comb begin
        q_d = q_q;
        if (do_push) begin
            q_d.mem[q_q.wr] = din;
            q_d.wr = (q_q.wr == AW'(DEPTH - 1)) ? '0 : q_q.wr + 1'b1;
        end
        if (do_pop) begin
            q_d.rd = (q_q.rd == AW'(DEPTH - 1)) ? '0 : q_q.rd + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   q_d.cnt = q_q.cnt + 1'b1;
            2'b01:   q_d.cnt = q_q.cnt - 1'b1;
            default: q_d.cnt = q_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

endmodule

// File: rtl/evt_tok_timer.sv
module evt_tok_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic [CW-1:0] limit,
    output logic          expired
);
    logic [CW-1:0] cnt_d, cnt_q;

    // cnt_q holds the non-stalled cycles already spent with the token
    assign expired = (cnt_q == limit - 1'b1);

    always_comb begin
        cnt_d = cnt_q;
        if (clr)     cnt_d = '0;
        else if (en) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/evt_word_fmt.sv
module evt_word_fmt
    import evt_pkg::*;
#(
    parameter int BUS_W  = 36,
    parameter int OUT_W  = 40,
    parameter int BCID_W = 12,
    parameter int NS     = 17,
    parameter int SRC_W  = 4
) (
    input  logic [BCID_W-1:0] bcid,
    input  logic [BUS_W-1:0]  bus,
    input  logic [SRC_W-1:0]  cand_src,
    input  logic [NS-1:0]     tmo,
    input  logic [NS-1:0]     mis,
    output logic [OUT_W-1:0]  hdr_w,
    output logic [OUT_W-1:0]  mult_w,
    output logic [OUT_W-1:0]  cand_w,
    output logic [OUT_W-1:0]  trl_w
);
    always_comb begin
        hdr_w = '0;
        hdr_w[OUT_W-1 -: 2]  = TAG_HEAD;
        hdr_w[BCID_W-1:0]    = bcid;

        mult_w = '0;
        mult_w[OUT_W-1 -: 2] = TAG_MULT;
        mult_w[BUS_W-1:0]    = bus;

        // Candidate words trade the bus tag bits for the source number
        cand_w = '0;
        cand_w[OUT_W-1 -: 2]     = TAG_CAND;
        cand_w[OUT_W-3 -: SRC_W] = cand_src;
        cand_w[BUS_W-3:0]        = bus[BUS_W-3:0];

        trl_w = '0;
        trl_w[OUT_W-1 -: 2]  = TAG_TRL;
        trl_w[OUT_W-3]       = |{tmo, mis};
        trl_w[NS-1:0]        = tmo;
        trl_w[2*NS-1:NS]     = mis;
    end

endmodule

// File: rtl/evt_collector.sv
module evt_collector
    import evt_pkg::*;
#(
    parameter int N_SRC      = 16,
    parameter int BUS_W      = 36,
    parameter int OUT_W      = 40,
    parameter int BCID_W     = 12,
    parameter int TMO_W      = 16,
    parameter int PEND_DEPTH = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               accept_i,
    input  logic [BCID_W-1:0]  bcid_i,
    input  logic [TMO_W-1:0]   timeout_cfg_i,
    output logic [N_SRC:0]     tok_o,
    input  logic               tok_ret_i,
    input  logic [BUS_W-1:0]   bus_data_i,
    input  logic               bus_vld_i,
    output logic               stall_o,
    output logic [OUT_W-1:0]   fifo_data_o,
    output logic               fifo_wr_o,
    input  logic               fifo_full_i,
    output logic               err_o
);
    localparam int NS     = N_SRC + 1;
    localparam int SIDX_W = $clog2(NS);
    localparam int SRC_W  = $clog2(N_SRC);

    typedef struct packed {
        evt_state_e        st;
        logic [SIDX_W-1:0] idx;
        logic [BCID_W-1:0] bcid;
        logic              hdr_seen;
        logic [NS-1:0]     tmo;
        logic [NS-1:0]     mis;
        logic              out_vld;
        logic [OUT_W-1:0]  out;
        logic              err;
    } ctl_t;

    ctl_t s_d, s_q;

    logic              can_load, in_src, word_take, hdr_ok, src_end;
    logic              q_pop, q_empty, tmr_exp;
    logic [BCID_W-1:0] q_bcid;
    logic [SRC_W-1:0]  cand_k;
    logic [OUT_W-1:0]  hdr_w, mult_w, cand_w, trl_w;

    evt_acc_queue #(.W(BCID_W), .DEPTH(PEND_DEPTH)) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (accept_i),
        .din   (bcid_i),
        .pop   (q_pop),
        .dout  (q_bcid),
        .empty (q_empty)
    );

    evt_tok_timer #(.CW(TMO_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (!in_src || src_end),
        .en      (in_src && can_load),
        .limit   (timeout_cfg_i),
        .expired (tmr_exp)
    );

    evt_word_fmt #(
        .BUS_W(BUS_W), .OUT_W(OUT_W), .BCID_W(BCID_W), .NS(NS), .SRC_W(SRC_W)
    ) u_fmt (
        .bcid     (s_q.bcid),
        .bus      (bus_data_i),
        .cand_src (cand_k),
        .tmo      (s_q.tmo),
        .mis      (s_q.mis),
        .hdr_w    (hdr_w),
        .mult_w   (mult_w),
        .cand_w   (cand_w),
        .trl_w    (trl_w)
    );

    // Single output holding stage toward the FIFO
    assign can_load    = !s_q.out_vld || !fifo_full_i;
    assign stall_o     = !can_load;
    assign fifo_wr_o   = s_q.out_vld && !fifo_full_i;
    assign fifo_data_o = s_q.out;
    assign err_o       = s_q.err;

    assign in_src    = (s_q.st == ST_SRC);
    assign word_take = in_src && bus_vld_i && can_load;
    assign hdr_ok    = (bus_data_i[BUS_W-1 -: 2] == BUS_HDR_TAG) &&
                       (bus_data_i[BCID_W-1:0] == s_q.bcid);
    assign src_end   = in_src && (tok_ret_i || (tmr_exp && can_load));
    assign cand_k    = SRC_W'(s_q.idx - 1'b1);

    for (genvar g = 0; g < NS; g++) begin : g_tok
        assign tok_o[g] = in_src && (s_q.idx == SIDX_W'(g));
    end

    always_comb begin
        s_d   = s_q;
        q_pop = 1'b0;
        if (fifo_wr_o) s_d.out_vld = 1'b0;

        case (s_q.st)
            ST_IDLE: begin
                if (!q_empty) begin
                    q_pop    = 1'b1;
                    s_d.bcid = q_bcid;
                    s_d.tmo  = '0;
                    s_d.mis  = '0;
                    s_d.st   = ST_HEAD;
                end
            end
            ST_HEAD: begin
                if (can_load) begin
                    s_d.out      = hdr_w;
                    s_d.out_vld  = 1'b1;
                    s_d.idx      = '0;
                    s_d.hdr_seen = 1'b0;
                    s_d.st       = ST_SRC;
                end
            end
            ST_SRC: begin
                if (word_take) begin
                    if (!s_q.hdr_seen) begin
                        s_d.hdr_seen = 1'b1;
                        if (!hdr_ok) s_d.mis[s_q.idx] = 1'b1;
                    end else begin
                        s_d.out     = (s_q.idx == '0) ? mult_w : cand_w;
                        s_d.out_vld = 1'b1;
                    end
                end
                if (src_end) begin
                    if (tok_ret_i) begin
                        if (!s_q.hdr_seen && !word_take) s_d.mis[s_q.idx] = 1'b1;
                    end else begin
                        s_d.tmo[s_q.idx] = 1'b1;
                    end
                    s_d.hdr_seen = 1'b0;
                    if (s_q.idx == SIDX_W'(NS - 1)) s_d.st = ST_TRAIL;
                    else                            s_d.idx = s_q.idx + 1'b1;
                end
            end
            ST_TRAIL: begin
                if (can_load) begin
                    s_d.out     = trl_w;
                    s_d.out_vld = 1'b1;
                    s_d.err     = |{s_q.tmo, s_q.mis};
                    s_d.st      = ST_IDLE;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/evt_collector_chk.sv
module evt_collector_chk #(
    parameter int NS    = 17,
    parameter int TMO_W = 16,
    parameter int OUT_W = 40
) (
    input logic             clk,
    input logic             rst_n,
    input logic             accept_i,
    input logic [NS-1:0]    tok_o,
    input logic             stall_o,
    input logic             fifo_wr_o,
    input logic [OUT_W-1:0] fifo_data_o,
    input logic [TMO_W-1:0] timeout_cfg_i
);
    logic [NS-1:0]  prev_tok_q;
    logic [TMO_W:0] run_q, run_now;
    logic           seen_q;

    // Non-stalled cycles the present token holder has had, this cycle included
    always_comb begin
        run_now = ((tok_o != prev_tok_q) ? '0 : run_q) + (TMO_W + 1)'(!stall_o);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_tok_q <= '0;
            run_q      <= '0;
            seen_q     <= 1'b0;
        end else begin
            prev_tok_q <= tok_o;
            run_q      <= run_now;
            seen_q     <= seen_q || accept_i;
        end
    end

    AST_TOKEN_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (|tok_o) |-> seen_q);  // R1

    AST_TOKEN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tok_o));  // R2

    AST_TOKEN_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|tok_o) |-> tok_o[0]);  // R2

    AST_TOKEN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        ((|tok_o) && (|$past(tok_o)) && (tok_o != $past(tok_o)))
            |-> (tok_o == ($past(tok_o) << 1)));  // R2

    AST_TRAILER_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr_o && (fifo_data_o[OUT_W-1 -: 2] == 2'b00))
            |-> (fifo_data_o[OUT_W-3] == (|fifo_data_o[2*NS-1:0])));  // R5

    AST_TOKEN_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
        (|tok_o) |-> (run_now <= {1'b0, timeout_cfg_i}));  // R6

    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |=> $stable(fifo_data_o));  // R7

endmodule

bind evt_collector evt_collector_chk #(
    .NS(N_SRC + 1), .TMO_W(TMO_W), .OUT_W(OUT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .accept_i      (accept_i),
    .tok_o         (tok_o),
    .stall_o       (stall_o),
    .fifo_wr_o     (fifo_wr_o),
    .fifo_data_o   (fifo_data_o),
    .timeout_cfg_i (timeout_cfg_i)
);

// File: tb/evt_collector_test.sv
module evt_collector_test;
    localparam int NS = 17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        accept_i = 1'b0;
    logic [11:0] bcid_i = '0;
    logic [15:0] timeout_cfg_i = 16'd64;
    logic [16:0] tok_o;
    logic        tok_ret_i;
    logic [35:0] bus_data_i;
    logic        bus_vld_i;
    logic        stall_o;
    logic [39:0] fifo_data_o;
    logic        fifo_wr_o;
    logic        fifo_full_i = 1'b0;
    logic        err_o;

    always #2 clk = ~clk;

    evt_collector uut (
        .clk(clk), .rst_n(rst_n), .accept_i(accept_i), .bcid_i(bcid_i),
        .timeout_cfg_i(timeout_cfg_i), .tok_o(tok_o), .tok_ret_i(tok_ret_i),
        .bus_data_i(bus_data_i), .bus_vld_i(bus_vld_i), .stall_o(stall_o),
        .fifo_data_o(fifo_data_o), .fifo_wr_o(fifo_wr_o),
        .fifo_full_i(fifo_full_i), .err_o(err_o)
    );

    int    n_checks = 0;
    int    n_fails  = 0;
    string cur_req  = "R3";

    int nw[NS];
    bit badh[NS], nohdr[NS], silent[NS];
    logic [39:0] expq[$];
    logic [11:0] bcq[$];
    logic [11:0] ev_bcid = '0;
    int served[64];
    int n_served = 0;
    int n_trailers = 0;
    int tok4_cycles = 0;
    int stall_cycles = 0;
    bit full_en = 1'b0;
    int cyc = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [35:0] bus_word(input logic [11:0] b, input int k, input int w);
        return {2'b00, b[7:0], 8'(k), 18'(w * 37 + k)};
    endfunction

    function automatic int tok_idx(input logic [16:0] t);
        for (int i = 0; i < NS; i++) if (t[i]) return i;
        return 0;
    endfunction

    // FIFO side: full pattern, write monitor
    initial forever begin
        @(negedge clk);
        cyc++;
        fifo_full_i = full_en && ((cyc % 5) < 2);
    end

    initial forever begin
        @(negedge clk);
        #1;
        if (tok_o[4]) tok4_cycles++;
        if (stall_o) stall_cycles++;
        if (fifo_wr_o && fifo_full_i)
            chk(1'b0, "R7", "write while full", 64'(fifo_wr_o), 64'd0);
        if (fifo_wr_o) begin
            if (fifo_data_o[39:38] == 2'b00) n_trailers++;
            if (expq.size() == 0) chk(1'b0, cur_req, "unexpected fifo word", 64'(fifo_data_o), 64'd0);
            else begin
                logic [39:0] e;
                e = expq.pop_front();
                chk(fifo_data_o == e, cur_req, "fifo word", 64'(fifo_data_o), 64'(e));
            end
        end
    end

    // Board model: serves whichever board holds the token
    task automatic send_word(input logic [35:0] d);
        bit acc;
        bus_data_i = d;
        bus_vld_i  = 1'b1;
        do begin
            #1 acc = !stall_o;
            @(negedge clk);
        end while (!acc);
    endtask

    task automatic serve(input int k);
        if (k == 0) ev_bcid = (bcq.size() != 0) ? bcq.pop_front() : 12'h0;
        if (silent[k]) begin
            while (tok_o[k]) @(negedge clk);
        end else begin
            if (!nohdr[k]) begin
                if (badh[k]) send_word({2'b10, 22'd0, ev_bcid ^ 12'h001});
                else         send_word({2'b10, 22'd0, ev_bcid});
            end
            for (int w = 0; w < nw[k]; w++) send_word(bus_word(ev_bcid, k, w));
            bus_vld_i = 1'b0;
            tok_ret_i = 1'b1;
        end
    endtask

    initial begin
        bus_vld_i = 1'b0; tok_ret_i = 1'b0; bus_data_i = '0;
        forever begin
            @(negedge clk);
            bus_vld_i = 1'b0;
            tok_ret_i = 1'b0;
            if (tok_o != '0) begin
                if (n_served < 64) served[n_served] = tok_idx(tok_o);
                n_served++;
                serve(tok_idx(tok_o));
            end
        end
    end

    // Expected stream for one event (R3, R4, R5, R6)
    task automatic expect_event(input logic [11:0] b);
        logic [16:0] tm, ms;
        tm = '0; ms = '0;
        expq.push_back({2'b11, 26'd0, b});
        for (int k = 0; k < NS; k++) begin
            if (silent[k]) tm[k] = 1'b1;
            else begin
                if (badh[k] || nohdr[k]) ms[k] = 1'b1;
                for (int w = 0; w < nw[k]; w++) begin
                    if (k == 0) expq.push_back({2'b01, 2'b00, bus_word(b, k, w)});
                    else        expq.push_back({2'b10, 4'(k - 1), bus_word(b, k, w)[33:0]});
                end
            end
        end
        expq.push_back({2'b00, |{tm, ms}, 3'b000, ms, tm});
    endtask

    task automatic clean_cfg();
        for (int k = 0; k < NS; k++) begin
            nw[k] = (k * 3) % 5; badh[k] = 1'b0; nohdr[k] = 1'b0; silent[k] = 1'b0;
        end
    endtask

    task automatic do_accept(input logic [11:0] b);
        @(negedge clk);
        accept_i = 1'b1; bcid_i = b; bcq.push_back(b);
        @(negedge clk);
        accept_i = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int guard;
        guard = 0;
        while ((expq.size() != 0 || tok_o != '0) && guard < 20000) begin
            @(negedge clk); guard++;
        end
        repeat (6) @(negedge clk);
        chk(expq.size() == 0, req, "words outstanding", 64'(expq.size()), 64'd0);
    endtask

    task automatic t_reset();
        #1;
        chk(tok_o == '0, "R10", "tok_o after reset", 64'(tok_o), 64'd0);
        chk(fifo_wr_o == 1'b0, "R10", "fifo_wr_o after reset", 64'(fifo_wr_o), 64'd0);
        chk(stall_o == 1'b0, "R10", "stall_o after reset", 64'(stall_o), 64'd0);
        chk(err_o == 1'b0, "R10", "err_o after reset", 64'(err_o), 64'd0);
    endtask

    task automatic t_no_accept();
        int act;
        act = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk); #1;
            if (tok_o != '0 || fifo_wr_o) act++;
        end
        chk(act == 0, "R1", "activity without accept", 64'(act), 64'd0);
    endtask

    task automatic t_basic();
        bit ord_ok;
        cur_req = "R3";
        clean_cfg();
        n_served = 0;
        expect_event(12'h123);
        do_accept(12'h123);
        wait_done("R4");
        ord_ok = (n_served == NS);
        for (int i = 0; i < NS; i++) if (served[i] != i) ord_ok = 1'b0;
        chk(ord_ok, "R2", "token visit order", 64'(n_served), 64'(NS));
        chk(err_o == 1'b0, "R9", "err_o clean event", 64'(err_o), 64'd0);
    endtask

    task automatic t_mismatch();
        cur_req = "R5";
        clean_cfg();
        badh[0] = 1'b1; badh[5] = 1'b1;
        nohdr[9] = 1'b1; nw[9] = 0;
        expect_event(12'h7A5);
        do_accept(12'h7A5);
        wait_done("R5");
        chk(err_o == 1'b1, "R9", "err_o after mismatch", 64'(err_o), 64'd1);
    endtask

    task automatic t_timeout();
        cur_req = "R6";
        clean_cfg();
        for (int k = 0; k < NS; k++) nw[k] = k % 4;
        silent[4] = 1'b1;
        timeout_cfg_i = 16'd8;
        tok4_cycles = 0;
        expect_event(12'h0F0);
        do_accept(12'h0F0);
        wait_done("R6");
        chk(tok4_cycles == 8, "R6", "token hold cycles of silent board", 64'(tok4_cycles), 64'd8);
        chk(err_o == 1'b1, "R9", "err_o after timeout", 64'(err_o), 64'd1);
        timeout_cfg_i = 16'd64;
    endtask

    task automatic t_clean_again();
        cur_req = "R9";
        clean_cfg();
        expect_event(12'h456);
        do_accept(12'h456);
        wait_done("R9");
        chk(err_o == 1'b0, "R9", "err_o returns low", 64'(err_o), 64'd0);
    endtask

    task automatic t_stall();
        cur_req = "R7";
        clean_cfg();
        for (int k = 0; k < NS; k++) nw[k] = 3 + (k % 3);
        stall_cycles = 0;
        full_en = 1'b1;
        expect_event(12'hABC);
        do_accept(12'hABC);
        wait_done("R7");
        full_en = 1'b0;
        chk(stall_cycles > 0, "R7", "stall_o raised under full", 64'(stall_cycles), 64'd1);
    endtask

    task automatic t_pending();
        cur_req = "R8";
        clean_cfg();
        for (int k = 0; k < NS; k++) nw[k] = k % 2;
        n_trailers = 0;
        for (int i = 0; i < 5; i++) expect_event(12'h200 + 12'(i));
        @(negedge clk);
        for (int i = 0; i < 6; i++) begin
            accept_i = 1'b1;
            bcid_i   = 12'h200 + 12'(i);
            if (i < 5) bcq.push_back(bcid_i);
            @(negedge clk);
        end
        accept_i = 1'b0;
        wait_done("R8");
        chk(n_trailers == 5, "R8", "events served with queue overflow", 64'(n_trailers), 64'd5);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        n_checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        clean_cfg();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_no_accept();
        t_basic();
        t_mismatch();
        t_timeout();
        t_clean_again();
        t_stall();
        t_pending();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule